// File: doc/BRIEF.md
# Loudest-Talker Conference Selector

This block forms the outgoing audio of one conference from the incoming audio of its members, one frame at a time. A frame holds one 16-bit linear sample per time slot, for up to 32 slots. Slots that belong to the conference are flagged by a membership mask. The block does not mix voices. It finds the loudest and the second-loudest member samples, comparing absolute values. The loudest member is sent the second-loudest sample, so that a speaker never hears its own voice. Every other member is sent the loudest sample.

Incoming samples are written into a receive store by slot number at any time. A start pulse captures the membership mask and begins a run of two passes. The first pass reads every slot and tracks the top two magnitudes. The second pass writes one outgoing sample for every slot into a transmit store, which the outside reads by slot number. A one-cycle done pulse marks the end of the run. Frame M is written while frame M-1 is processed. Frame M is then processed during frame M+1, and its result is read out during frame M+2. This two-frame delay is set by when the surrounding system raises start.

Top module: `conf_loudest_sel`

## Requirements
- R1: After reset, busy and done are 0 and every slot of the transmit store reads 0 through rd_sample.
- R2: Loudness is the absolute value of the two's-complement sample, so a negative sample outranks any positive sample of smaller magnitude.
- R3: The member with the largest magnitude receives the sample of the member with the second-largest magnitude.
- R4: Every member other than the loudest receives the sample of the loudest member.
- R5: A slot whose member_mask bit (bit n for slot n) is 0 receives 0 and takes no part in the comparison, however loud it is.
- R6: When two members have equal magnitude, the member with the lower slot number ranks higher.
- R7: The magnitude of -32768 saturates to 32767, so it ties with +32767 and the tie falls to the lower slot.
- R8: With exactly one member, that member receives 0. With no members, every slot receives 0.
- R9: done rises for exactly one cycle, 64 clock cycles (2 × slots) after the edge that accepts start. busy is 1 from that edge until done. A start that arrives while busy is ignored.
- R10: member_mask is sampled only on the edge that accepts start. Changes to it during a run have no effect on that run.
- R11: The transmit store keeps its contents between runs. Writes to the receive store without a start do not change rd_sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Writes wr_sample into the receive store |
| wr_slot | input | 5 | Receive store slot being written |
| wr_sample | input | 16 | Incoming linear sample, two's complement |
| member_mask | input | 32 | Conference membership, bit n for slot n |
| start | input | 1 | Pulse that begins a run when idle |
| rd_slot | input | 5 | Transmit store slot being read |
| rd_sample | output | 16 | Outgoing sample of rd_slot, combinational read |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse at the end of a run |

## Verification
The bench places equal magnitudes of opposite sign in two slots. A design that ranked by later slot, or by signed value, would pick the wrong talker and swap what the two groups hear. It pairs +32767 in a low slot with -32768 in a higher one. An unsaturated absolute value would make the higher slot win. It makes a non-member the loudest slot in the frame, which catches logic that forgets the mask during the comparison or the routing. It also covers a lone member and an empty conference, where a design without validity tracking would send stale or self audio. Finally it changes the mask and pulses start in the middle of a run, and writes new input between runs, which exposes late mask sampling, restarts and transmit stores that follow the input.

// File: rtl/conf_pkg.sv
// Shared types for the conference selector.
// Assumes: one conference per instance, single clock domain.
package conf_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SCAN  = 2'd1,
        ST_ROUTE = 2'd2
    } seq_state_t;
endpackage

// File: rtl/conf_mag_abs.sv
// Saturating magnitude of a two's-complement sample.
// Assumes W >= 2. The most negative code maps to the most positive value,
// so the result always fits in W-1 magnitude bits.
module conf_mag_abs #(
    parameter int W = 16
) (
    input  logic [W-1:0] smp,
    output logic [W-1:0] mag
);
    localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};
    localparam logic [W-1:0] MOST_POS = {1'b0, {(W-1){1'b1}}};

    // Purpose: negate negative inputs, clamping the single overflow case.
    always_comb begin
        if (smp == MOST_NEG) begin
            mag = MOST_POS;
        end else if (smp[W-1]) begin
            mag = W'(~smp + 1'b1);
        end else begin
            mag = smp;
        end
    end
endmodule

// File: rtl/conf_sample_store.sv
// Slot-addressed sample store: one synchronous write port, one
// combinational read port, cleared to zero by reset.
// Assumes DEPTH is a power of two matching the address width.
module conf_sample_store #(
    parameter int DEPTH = 32,
    parameter int W     = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] mem [DEPTH];

    // Purpose: clear on reset, otherwise store the addressed sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= '0;
            end
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // Purpose: unregistered read of the addressed slot.
    always_comb rdata = mem[raddr];
endmodule

// File: rtl/conf_top2_tracker.sv
// Tracks the largest and second-largest magnitudes offered in one pass.
// Assumes candidates arrive in ascending slot order. A strict greater-than
// therefore keeps the earlier (lower) slot on ties.
module conf_top2_tracker #(
    parameter int W  = 16,
    parameter int SW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          en,
    input  logic [SW-1:0] slot,
    input  logic [W-1:0]  mag,
    input  logic [W-1:0]  sample,
    output logic          best_valid,
    output logic [SW-1:0] best_slot,
    output logic [W-1:0]  best_sample,
    output logic          sec_valid,
    output logic [W-1:0]  sec_sample
);
    logic [W-1:0] best_mag;
    logic [W-1:0] sec_mag;
    logic         beats_best;
    logic         beats_sec;

    // Purpose: rank the candidate against the current leaders.
    always_comb begin
        beats_best = !best_valid || (mag > best_mag);
        beats_sec  = !sec_valid  || (mag > sec_mag);
    end

    // Purpose: update the top-two registers, demoting the leader when beaten.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            best_valid  <= 1'b0;
            best_slot   <= '0;
            best_mag    <= '0;
            best_sample <= '0;
            sec_valid   <= 1'b0;
            sec_mag     <= '0;
            sec_sample  <= '0;
        end else if (en) begin
            if (beats_best) begin
                sec_valid   <= best_valid;
                sec_mag     <= best_mag;
                sec_sample  <= best_sample;
                best_valid  <= 1'b1;
                best_slot   <= slot;
                best_mag    <= mag;
                best_sample <= sample;
            end else if (beats_sec) begin
                sec_valid  <= 1'b1;
                sec_mag    <= mag;
                sec_sample <= sample;
            end
        end
    end

    // R2: the runner-up never exceeds the leader in magnitude
    p_order_kept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        sec_valid |-> (best_mag >= sec_mag));

    // R8: a runner-up exists only once a leader exists
    p_second_needs_best_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sec_valid |-> best_valid);

    // R6: a new leader only takes over on a strictly larger magnitude
    p_tie_keeps_lower_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !clear && best_valid && (mag == best_mag)) |=> $stable(best_slot));
endmodule

// File: rtl/conf_scan_seq.sv
// Run sequencer: an accepted start launches a scan pass and then a route
// pass, each over all slots in ascending order, and ends with a done pulse.
// Assumes NUM_SLOTS is a power of two. start is ignored while a run is active.
module conf_scan_seq
    import conf_pkg::*;
#(
    parameter int NUM_SLOTS = 32,
    localparam int SW       = $clog2(NUM_SLOTS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    output logic          start_acc,
    output logic          scan_en,
    output logic          route_en,
    output logic [SW-1:0] idx,
    output logic          busy,
    output logic          done
);
    localparam logic [SW-1:0] LAST = SW'(NUM_SLOTS - 1);

    seq_state_t state;

    // Purpose: decode the phase strobes from the state.
    always_comb begin
        start_acc = start && (state == ST_IDLE);
        scan_en   = (state == ST_SCAN);
        route_en  = (state == ST_ROUTE);
        busy      = (state != ST_IDLE);
    end

    // Purpose: advance the phase, step the slot index and raise done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            idx   <= '0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    idx <= '0;
                    if (start) begin
                        state <= ST_SCAN;
                    end
                end
                ST_SCAN: begin
                    idx <= idx + 1'b1;
                    if (idx == LAST) begin
                        state <= ST_ROUTE;
                    end
                end
                ST_ROUTE: begin
                    idx <= idx + 1'b1;
                    if (idx == LAST) begin
                        state <= ST_IDLE;
                        done  <= 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R9: done lasts one cycle
    p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9: done follows the last cycle of the route pass
    p_done_after_route_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(route_en) && !busy));

    // R9: a start during a run does not restart it
    p_start_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && (idx != LAST)) |=> (busy && (idx == $past(idx) + 1'b1)));
endmodule

// File: rtl/conf_loudest_sel.sv
// Loudest-talker conference selector, top level.
// Receive store -> saturating magnitude -> top-two tracker during the scan
// pass. Router -> transmit store during the route pass.
// Assumes one conference per instance and the membership mask stable only
// at the start edge.
module conf_loudest_sel #(
    parameter int NUM_SLOTS = 32,
    parameter int SAMPLE_W  = 16,
    localparam int SW       = $clog2(NUM_SLOTS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [SW-1:0]        wr_slot,
    input  logic [SAMPLE_W-1:0]  wr_sample,
    input  logic [NUM_SLOTS-1:0] member_mask,
    input  logic                 start,
    input  logic [SW-1:0]        rd_slot,
    output logic [SAMPLE_W-1:0]  rd_sample,
    output logic                 busy,
    output logic                 done
);
    localparam logic [SAMPLE_W-1:0] MAG_MAX = {1'b0, {(SAMPLE_W-1){1'b1}}};

    logic                 start_acc;
    logic                 scan_en;
    logic                 route_en;
    logic [SW-1:0]        idx;
    logic [NUM_SLOTS-1:0] mask_q;
    logic [SAMPLE_W-1:0]  rx_sample;
    logic [SAMPLE_W-1:0]  rx_mag;
    logic                 best_valid;
    logic [SW-1:0]        best_slot;
    logic [SAMPLE_W-1:0]  best_sample;
    logic                 sec_valid;
    logic [SAMPLE_W-1:0]  sec_sample;
    logic [SAMPLE_W-1:0]  tx_wdata;
    logic                 is_member;

    conf_scan_seq #(.NUM_SLOTS(NUM_SLOTS)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .start_acc(start_acc),
        .scan_en  (scan_en),
        .route_en (route_en),
        .idx      (idx),
        .busy     (busy),
        .done     (done)
    );

    // Purpose: capture the membership for the whole run on the start edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else if (start_acc) begin
            mask_q <= member_mask;
        end
    end

    // Purpose: membership of the slot currently addressed by the sequencer.
    always_comb is_member = mask_q[idx];

    conf_sample_store #(.DEPTH(NUM_SLOTS), .W(SAMPLE_W)) u_rx_store (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (wr_en),
        .waddr(wr_slot),
        .wdata(wr_sample),
        .raddr(idx),
        .rdata(rx_sample)
    );

    conf_mag_abs #(.W(SAMPLE_W)) u_abs (
        .smp(rx_sample),
        .mag(rx_mag)
    );

    conf_top2_tracker #(.W(SAMPLE_W), .SW(SW)) u_top2 (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (start_acc),
        .en         (scan_en && is_member),
        .slot       (idx),
        .mag        (rx_mag),
        .sample     (rx_sample),
        .best_valid (best_valid),
        .best_slot  (best_slot),
        .best_sample(best_sample),
        .sec_valid  (sec_valid),
        .sec_sample (sec_sample)
    );

    // Purpose: choose the outgoing sample of the slot in the route pass.
    always_comb begin
        if (!is_member) begin
            tx_wdata = '0;
        end else if (best_valid && (idx == best_slot)) begin
            tx_wdata = sec_valid ? sec_sample : '0;
        end else begin
            tx_wdata = best_valid ? best_sample : '0;
        end
    end

    conf_sample_store #(.DEPTH(NUM_SLOTS), .W(SAMPLE_W)) u_tx_store (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (route_en),
        .waddr(idx),
        .wdata(tx_wdata),
        .raddr(rd_slot),
        .rdata(rd_sample)
    );

    // R7: magnitudes offered to the tracker never exceed the positive limit
    p_mag_sat_r7: assert property (@(posedge clk) disable iff (!rst_n)
        scan_en |-> (rx_mag <= MAG_MAX));

    // R10: the captured mask does not move during a run
    p_mask_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !start_acc) |=> $stable(mask_q));

    // R11: with no run active the transmit output only follows rd_slot
    p_tx_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start && $past(!busy) && $stable(rd_slot)) |-> $stable(rd_sample));

    // R8: nothing is ranked before a run has scanned any member
    p_fresh_run_r8: assert property (@(posedge clk) disable iff (!rst_n)
        start_acc |=> (!best_valid && !sec_valid));
endmodule

// File: tb/tb_conf_loudest_sel.sv
// Self-checking bench: a vector table walked by one loop, then directed tests.
module tb_conf_loudest_sel;
    localparam int N  = 32;
    localparam int W  = 16;
    localparam int SW = 5;

    typedef struct packed {
        logic [N-1:0]         mask;
        logic [3:0][SW-1:0]   slot;
        logic [3:0][W-1:0]    val;
        logic [5:0]           loud;     // 6'h3F: no member
        logic [W-1:0]         to_loud;
        logic [W-1:0]         to_rest;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        // R2 R3 R4 R5: negative loudest, loud non-member slot 20
        '{mask: 32'h0000_00FF, slot: '{5'd1, 5'd4, 5'd6, 5'd20},
          val: '{16'd100, 16'hFE0C, 16'd300, 16'd9000},
          loud: 6'd4, to_loud: 16'd300, to_rest: 16'hFE0C},
        // R6: equal magnitude, lower slot wins
        '{mask: 32'hFFFF_FFFF, slot: '{5'd7, 5'd2, 5'd30, 5'd0},
          val: '{16'hFB50, 16'd1200, 16'd50, 16'd0},
          loud: 6'd2, to_loud: 16'hFB50, to_rest: 16'd1200},
        // R7: -32768 ties +32767, lower slot 3 wins
        '{mask: 32'h0000_0209, slot: '{5'd3, 5'd9, 5'd0, 5'd0},
          val: '{16'h7FFF, 16'h8000, 16'd0, 16'd0},
          loud: 6'd3, to_loud: 16'h8000, to_rest: 16'h7FFF},
        // R8: single member hears silence
        '{mask: 32'h0010_0000, slot: '{5'd20, 5'd5, 5'd5, 5'd5},
          val: '{16'hFCF7, 16'd4000, 16'd4000, 16'd4000},
          loud: 6'd20, to_loud: 16'd0, to_rest: 16'd0},
        // R8: empty conference
        '{mask: 32'h0000_0000, slot: '{5'd1, 5'd1, 5'd1, 5'd1},
          val: '{16'd5, 16'd5, 16'd5, 16'd5},
          loud: 6'h3F, to_loud: 16'd0, to_rest: 16'd0},
        // R5: loud non-member 15 excluded from the ranking
        '{mask: 32'h8000_0001, slot: '{5'd0, 5'd31, 5'd15, 5'd15},
          val: '{16'hFFF6, 16'd20, 16'h8AD0, 16'h8AD0},
          loud: 6'd31, to_loud: 16'hFFF6, to_rest: 16'd20}
    };

    logic          clk;
    logic          rst_n;
    logic          wr_en;
    logic [SW-1:0] wr_slot;
    logic [W-1:0]  wr_sample;
    logic [N-1:0]  member_mask;
    logic          start;
    logic [SW-1:0] rd_slot;
    logic [W-1:0]  rd_sample;
    logic          busy;
    logic          done;

    int n_tests = 0;
    int n_fail  = 0;

    conf_loudest_sel #(.NUM_SLOTS(N), .SAMPLE_W(W)) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_slot    (wr_slot),
        .wr_sample  (wr_sample),
        .member_mask(member_mask),
        .start      (start),
        .rd_slot    (rd_slot),
        .rd_sample  (rd_sample),
        .busy       (busy),
        .done       (done)
    );

    initial clk = 1'b0;
    always #5 clk = ~clk;

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic write_slot(input logic [SW-1:0] s, input logic [W-1:0] v);
        @(negedge clk);
        wr_en = 1'b1; wr_slot = s; wr_sample = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic load_vec(input vec_t v);
        for (int s = 0; s < N; s++) write_slot(SW'(s), '0);
        for (int k = 0; k < 4; k++) write_slot(v.slot[k], v.val[k]);
    endtask

    // Pulse start, optionally disturb mid-run, return cycles to done.
    task automatic run(input logic [N-1:0] m, input bit disturb, output int cycles);
        @(negedge clk);
        member_mask = m; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cycles = 1;
        while (!done && cycles < 1000) begin
            if (disturb && cycles == 10) begin
                start = 1'b1; member_mask = '0;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            cycles++;
        end
        start = 1'b0;
    endtask

    task automatic read_slot(input int s, output logic [W-1:0] v);
        @(negedge clk);
        rd_slot = SW'(s);
        #1 v = rd_sample;
    endtask

    task automatic check_vec(input vec_t v, input string tag);
        logic [W-1:0] got;
        logic [W-1:0] exp;
        for (int s = 0; s < N; s++) begin
            read_slot(s, got);
            if (!v.mask[s]) exp = '0;
            else if (v.loud == 6'(s)) exp = v.to_loud;
            else exp = v.to_rest;
            check(got == exp, tag, {16'h0, got}, {16'h0, exp});
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [W-1:0] got;
        int cyc;
        rst_n = 1'b0; wr_en = 1'b0; wr_slot = '0; wr_sample = '0;
        member_mask = '0; start = 1'b0; rd_slot = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        @(negedge clk);
        check(!busy, "R1 busy", {31'h0, busy}, 0);
        check(!done, "R1 done", {31'h0, done}, 0);
        for (int s = 0; s < N; s++) begin
            read_slot(s, got);
            check(got == '0, "R1 tx cleared", {16'h0, got}, 0);
        end

        // Table walk: R2..R8
        for (int i = 0; i < NV; i++) begin
            load_vec(VECS[i]);
            run(VECS[i].mask, 1'b0, cyc);
            check(cyc == 65, "R9 latency", cyc, 65);
            check_vec(VECS[i], "R2-vector");
        end

        // R9 R10: start pulse and mask change mid-run have no effect
        load_vec(VECS[0]);
        @(negedge clk);
        member_mask = VECS[0].mask; start = 1'b1;
        #1 check(!busy, "R9 busy idle", {31'h0, busy}, 0);
        @(negedge clk);
        start = 1'b0;
        check(busy, "R9 busy set", {31'h0, busy}, 1);
        cyc = 1;
        while (!done && cyc < 1000) begin
            start = (cyc == 10);
            if (cyc == 10) member_mask = '0;
            @(negedge clk);
            cyc++;
        end
        start = 1'b0;
        check(cyc == 65, "R9 restart ignored", cyc, 65);
        check(!busy, "R9 busy clear at done", {31'h0, busy}, 0);
        @(negedge clk);
        check(!done, "R9 done one cycle", {31'h0, done}, 0);
        check_vec(VECS[0], "R10 mask captured");

        // R11: new receive writes without start leave output untouched
        for (int s = 0; s < N; s++) write_slot(SW'(s), 16'h1234);
        check_vec(VECS[0], "R11 tx held");

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule